// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 interrupt sources into one register bank and drives a single interrupt request line. Hardware raises a cause bit with a one-cycle (or longer) pulse on its event input. Software, through a simple register port with separate read and write strobes, can read the raw or masked causes, force causes, and manage the mask in three ways: by writing it directly, by setting mask bits, or by clearing mask bits. Each interrupt source uses the same bit index in every register.

A per-bit policy register selects how each cause bit is acknowledged. A policy bit of 0 makes the cause bit write-one-to-clear. A policy bit of 1 makes it clear-on-read, so reading it acknowledges it. The interrupt request output is registered and is high whenever any unmasked cause bit is set. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset the policy, cause and mask registers are all zero, irqOut is low, and every register reads as zero.
- R2: Word offsets are 0 policy, 1 cause, 2 masked cause, 3 cause set, 4 mask, 5 mask set and 6 mask clear. Read data is valid on regRdData in the cycle after regRdEn. Offsets 3, 5, 6 and 7 read as zero.
- R3: A high bit on hwEvent sets the matching cause bit at the next clock edge. When an event and a clear (write-one or read) hit the same bit in the same cycle, the bit stays set.
- R4: Writing offset 3 sets the cause bits that are 1 in the write data. Bits written as 0 are left unchanged.
- R5: For a bit whose policy is 0, writing 1 to that bit at offset 1 clears it, and reading the cause register leaves it unchanged.
- R6: For a bit whose policy is 0, writing 1 at offset 2 clears the cause bit only when its mask bit is 0.
- R7: For a bit whose policy is 1, a read of offset 1 clears the set bits that the read returns, and writes to offsets 1 and 2 do not clear it.
- R8: For a bit whose policy is 1, a read of offset 2 clears only the returned bits, which are the unmasked ones. Masked bits keep their value.
- R9: Offset 2 reads as the cause bits ANDed with the inverse of the mask.
- R10: Offset 4 is read/write. A 1 written at offset 5 sets the matching mask bit, and a 1 written at offset 6 clears it. Zero bits leave the mask unchanged.
- R11: irqOut is the registered OR of all masked-cause bits. It changes at the same clock edge as the cause or mask register.
- R12: The policy register at offset 0 is read/write and holds its value until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Read data, one cycle after regRdEn |
| hwEvent | input | 32 | Hardware event inputs, one per cause bit |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle: an event bit is always captured into the cause register, the forcing register never drops a cause, the mask and policy registers move only when written, clear-on-read bits are gone after a read of the cause register, and irqOut agrees with the masked causes. Some behaviours can only be shown by the bench scenarios, because they depend on a particular history. These are the register offset map, the difference between clearing through the raw and the masked register, the fact that writes cannot clear clear-on-read bits, and a clear losing to an event in the same cycle.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFF_CTL   = 3'd0;
  localparam logic [REG_AW-1:0] OFF_CAUSE = 3'd1;
  localparam logic [REG_AW-1:0] OFF_MASKD = 3'd2;
  localparam logic [REG_AW-1:0] OFF_SET   = 3'd3;
  localparam logic [REG_AW-1:0] OFF_MASK  = 3'd4;
  localparam logic [REG_AW-1:0] OFF_MSET  = 3'd5;
  localparam logic [REG_AW-1:0] OFF_MCLR  = 3'd6;

  typedef struct packed {
    logic wrCtl;
    logic wrCause;
    logic wrMasked;
    logic wrSet;
    logic wrMask;
    logic wrMaskSet;
    logic wrMaskClr;
    logic rdAny;
    logic rdCause;
    logic rdMasked;
    logic [REG_AW-1:0] rdSel;
  } bankStrobes_t;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output bankStrobes_t      strb
);
  always_comb begin
    strb.wrCtl     = regWrEn && (regAddr == OFF_CTL);
    strb.wrCause   = regWrEn && (regAddr == OFF_CAUSE);
    strb.wrMasked  = regWrEn && (regAddr == OFF_MASKD);
    strb.wrSet     = regWrEn && (regAddr == OFF_SET);
    strb.wrMask    = regWrEn && (regAddr == OFF_MASK);
    strb.wrMaskSet = regWrEn && (regAddr == OFF_MSET);
    strb.wrMaskClr = regWrEn && (regAddr == OFF_MCLR);
    strb.rdAny     = regRdEn;
    strb.rdCause   = regRdEn && (regAddr == OFF_CAUSE);
    strb.rdMasked  = regRdEn && (regAddr == OFF_MASKD);
    strb.rdSel     = regAddr;
  end
endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobes_t       strb,
  input  logic [NUM_IRQ-1:0] wrData,
  input  logic [NUM_IRQ-1:0] hwEvent,
  output logic [NUM_IRQ-1:0] rdData,
  output logic [NUM_IRQ-1:0] ctlQ,
  output logic [NUM_IRQ-1:0] causeQ,
  output logic [NUM_IRQ-1:0] maskQ,
  output logic               irqQ
);
  logic [NUM_IRQ-1:0] maskedNow;
  logic [NUM_IRQ-1:0] forceSet;
  logic [NUM_IRQ-1:0] wrClrReq;
  logic [NUM_IRQ-1:0] rdClrReq;
  logic [NUM_IRQ-1:0] causeD;
  logic [NUM_IRQ-1:0] maskD;

  assign maskedNow = causeQ & ~maskQ;
  assign forceSet  = strb.wrSet ? wrData : '0;
  assign wrClrReq  = (strb.wrCause ? wrData : '0) |
                     (strb.wrMasked ? (wrData & ~maskQ) : '0);
  assign rdClrReq  = (strb.rdCause ? '1 : '0) |
                     (strb.rdMasked ? ~maskQ : '0);

  // per-bit clearing policy, event has priority over any clear
  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    logic clrHit;
    assign clrHit    = ctlQ[b] ? rdClrReq[b] : wrClrReq[b];
    assign causeD[b] = hwEvent[b] | forceSet[b] | (causeQ[b] & ~clrHit);
  end

  always_comb begin
    maskD = maskQ;
    if (strb.wrMask)    maskD = wrData;
    if (strb.wrMaskSet) maskD = maskD | wrData;
    if (strb.wrMaskClr) maskD = maskD & ~wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ   <= '0;
      causeQ <= '0;
      maskQ  <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (strb.wrCtl) ctlQ <= wrData;
      causeQ <= causeD;
      maskQ  <= maskD;
      irqQ   <= |(causeD & ~maskD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdAny) begin
      case (strb.rdSel)
        OFF_CTL:   rdData <= ctlQ;
        OFF_CAUSE: rdData <= causeQ;
        OFF_MASKD: rdData <= maskedNow;
        OFF_MASK:  rdData <= maskQ;
        default:   rdData <= '0;
      endcase
    end else begin
      rdData <= '0;
    end
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [NUM_IRQ-1:0] regWrData,
  input  logic               regRdEn,
  output logic [NUM_IRQ-1:0] regRdData,
  input  logic [NUM_IRQ-1:0] hwEvent,
  output logic               irqOut
);
  bankStrobes_t       strb;
  logic [NUM_IRQ-1:0] ctlVal;
  logic [NUM_IRQ-1:0] causeVal;
  logic [NUM_IRQ-1:0] maskVal;

  irq_bank_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  irq_bank_dp #(.NUM_IRQ(NUM_IRQ)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .hwEvent (hwEvent),
    .rdData  (regRdData),
    .ctlQ    (ctlVal),
    .causeQ  (causeVal),
    .maskQ   (maskVal),
    .irqQ    (irqOut)
  );
endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [REG_AW-1:0]  regAddr,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [NUM_IRQ-1:0] hwEvent,
  input logic [NUM_IRQ-1:0] ctlVal,
  input logic [NUM_IRQ-1:0] causeVal,
  input logic [NUM_IRQ-1:0] maskVal,
  input logic               irqOut
);
  logic wrSetC, maskWrC, ctlWrC, rdCauseC;
  assign wrSetC   = regWrEn && (regAddr == OFF_SET);
  assign maskWrC  = regWrEn && (regAddr == OFF_MASK || regAddr == OFF_MSET || regAddr == OFF_MCLR);
  assign ctlWrC   = regWrEn && (regAddr == OFF_CTL);
  assign rdCauseC = regRdEn && (regAddr == OFF_CAUSE);

  AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(hwEvent) & ~causeVal) == '0)); // R3

  AST_SET_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (wrSetC && !regRdEn) |=> ((causeVal & $past(causeVal)) == $past(causeVal))); // R4

  AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdCauseC && !regWrEn) |=> ((causeVal & $past(ctlVal & ~hwEvent)) == '0)); // R7

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrC |=> $stable(maskVal)); // R10

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrC |=> $stable(ctlVal)); // R12

  AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(causeVal & ~maskVal))); // R11
endmodule

bind irq_cause_bank irq_cause_bank_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .hwEvent  (hwEvent),
  .ctlVal   (ctlVal),
  .causeVal (causeVal),
  .maskVal  (maskVal),
  .irqOut   (irqOut)
);

// File: tb/irq_cause_bank_tb_top.sv
module irq_cause_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [31:0] hwEvent = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_cause_bank dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .hwEvent(hwEvent), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk);
    hwEvent = e;
    @(negedge clk);
    hwEvent = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 R2 reset read off %0d", a), v, 32'd0);
    end
  endtask

  task automatic t_event_w1c();
    logic [31:0] v;
    pulse(32'h0000_0011);
    check("R11 irq after event", {31'd0, irqOut}, 32'd1);
    rd(3'd1, v); check("R3 event sets cause", v, 32'h11);
    rd(3'd1, v); check("R5 read keeps w1c bits", v, 32'h11);
    wr(3'd1, 32'h1);
    rd(3'd1, v); check("R5 w1c clears bit0", v, 32'h10);
    wr(3'd1, 32'h10);
    check("R11 irq low when empty", {31'd0, irqOut}, 32'd0);
    rd(3'd1, v); check("R5 cause empty", v, 32'h0);
  endtask

  task automatic t_set_mask();
    logic [31:0] v;
    wr(3'd3, 32'h8000_0003);
    rd(3'd1, v); check("R4 force set", v, 32'h8000_0003);
    wr(3'd3, 32'h0);
    rd(3'd1, v); check("R4 zero write no effect", v, 32'h8000_0003);
    rd(3'd3, v); check("R2 set reg reads zero", v, 32'h0);
    wr(3'd4, 32'h1);
    rd(3'd4, v); check("R10 mask direct", v, 32'h1);
    rd(3'd2, v); check("R9 masked view", v, 32'h8000_0002);
    wr(3'd5, 32'h8000_0000);
    wr(3'd5, 32'h0);
    rd(3'd4, v); check("R10 mask set", v, 32'h8000_0001);
    wr(3'd6, 32'h1);
    wr(3'd6, 32'h0);
    rd(3'd4, v); check("R10 mask clear", v, 32'h8000_0000);
    rd(3'd2, v); check("R9 masked after change", v, 32'h3);
    rd(3'd6, v); check("R2 mask clear reads zero", v, 32'h0);
  endtask

  task automatic t_masked_w1c();
    logic [31:0] v;
    wr(3'd2, 32'h8000_0003);
    rd(3'd1, v); check("R6 masked w1c spares masked bit", v, 32'h8000_0000);
    check("R11 irq low while masked", {31'd0, irqOut}, 32'd0);
    wr(3'd6, 32'h8000_0000);
    check("R11 irq on unmask", {31'd0, irqOut}, 32'd1);
    wr(3'd1, 32'h8000_0000);
    rd(3'd1, v); check("R5 clear bit31", v, 32'h0);
  endtask

  task automatic t_cor();
    logic [31:0] v;
    wr(3'd0, 32'h0000_00FF);
    rd(3'd0, v); check("R12 policy readback", v, 32'hFF);
    wr(3'd3, 32'h0000_0F0F);
    wr(3'd1, 32'h0000_0F0F);
    wr(3'd2, 32'h0000_000F);
    rd(3'd1, v); check("R7 writes do not clear cor bits", v, 32'hF);
    rd(3'd1, v); check("R7 read cleared cor bits", v, 32'h0);
    wr(3'd3, 32'h0000_000F);
    wr(3'd4, 32'h0000_0003);
    rd(3'd2, v); check("R8 masked read value", v, 32'hC);
    rd(3'd2, v); check("R8 unmasked bits cleared", v, 32'h0);
    check("R8 irq low, masked bits only", {31'd0, irqOut}, 32'd0);
    wr(3'd4, 32'h0);
    check("R8 masked bits survived", {31'd0, irqOut}, 32'd1);
    rd(3'd2, v); check("R8 masked bits remain", v, 32'h3);
    check("R11 irq low after cor read", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_event_wins();
    logic [31:0] v;
    wr(3'd3, 32'h0000_0101);
    @(negedge clk);
    regAddr = 3'd1; regWrData = 32'h100; regWrEn = 1'b1; hwEvent = 32'h100;
    @(negedge clk);
    regWrEn = 1'b0; hwEvent = '0;
    regAddr = 3'd1; regRdEn = 1'b1; hwEvent = 32'h1;
    @(negedge clk);
    regRdEn = 1'b0; hwEvent = '0;
    check("R3 read during event returns", regRdData, 32'h101);
    rd(3'd1, v); check("R3 event beats w1c and cor", v, 32'h101);
    rd(3'd1, v); check("R7 cor bit cleared next", v, 32'h100);
    rd(3'd0, v); check("R12 policy held", v, 32'hFF);
    rd(3'd7, v); check("R2 unused offset zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_event_w1c();
    t_set_mask();
    t_masked_w1c();
    t_cor();
    t_event_wins();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule